// File: doc/BRIEF.md
# Global Shutter Exposure and Readout Sequencer

This block drives the timing of a global-shutter pixel array. It holds the whole array in reset, releases it so that all pixels integrate together, and then issues one sample strobe. The strobe moves every pixel onto its storage node at the same moment. After a fixed frame overhead, the block walks the stored image out one line at a time. Each line starts with a row overhead period, followed by a data window. During that window the block presents the row address and a line-valid qualifier, and a frame-valid signal spans the whole line sequence.

The exposure can be timed in two ways. In internal timing, a start delay and an integration length come from configuration inputs, and frames repeat without outside help. In triggered timing, a trigger level sets the exposure window directly. The block can also run in two orderings. In the overlapped ordering, the next exposure runs while the current frame is read out. In the serial ordering, the next exposure waits until readout has finished.

A sample cannot take place while a readout is still running. An exposure that ends too early is held open until the readout finishes, and a one-cycle flag reports the deferral. The timing mode, the ordering and the line count are captured at each sample event, so a change takes effect at a frame boundary.

Top module: `gs_readout_seq`

## Requirements
- R1: While reset is asserted, pixRst is 1 and sampleStb, frameValid, lineValid, lateTrig and rowAddr are all 0.
- R2: Every sample event gives a sampleStb pulse exactly one cycle long. pixRst is 1 in that same cycle, so the array goes back into reset as it is sampled.
- R3: frameValid rises exactly FOT_CYC cycles after the cycle in which sampleStb is high. It stays low during this frame overhead.
- R4: Each line consists of ROT_CYC cycles with lineValid low (row overhead) followed by LINE_CYC cycles with lineValid high. rowAddr equals the line index, counting 0, 1, 2 and so on within the frame, while lineValid is high.
- R5: A frame has exactly numLines lines. frameValid stays high for numLines*(ROT_CYC+LINE_CYC) cycles, from the end of the frame overhead until the last line ends.
- R6: With slaveMode=0, after a frame starts, pixRst stays high for expDelay+1 cycles. It then stays low for exactly expLen cycles before the sample, provided no deferral occurs.
- R7: With slaveMode=0 and pipeMode=0, a new frame starts only after the readout ends. Successive sampleStb pulses are R+expDelay+expLen+2 cycles apart, where R = FOT_CYC+numLines*(ROT_CYC+LINE_CYC).
- R8: With pipeMode=1, the next exposure starts in the sample cycle itself. With slaveMode=0, successive samples are max(expDelay+expLen+1, R+1) cycles apart.
- R9: With slaveMode=1, pixRst falls on the first clock edge at which trig is seen high. The sample follows on the first edge at which trig is seen low. pixRst is therefore low for exactly as many cycles as trig was high, and expLen and expDelay have no effect.
- R10: If an exposure ends while a readout is still busy, the sample is deferred until the cycle after the readout ends. pixRst stays low meanwhile, and lateTrig is high for one cycle, in the cycle right after the exposure ended.
- R11: slaveMode, pipeMode and numLines take effect only at a sample event. A frame reads out the numLines value present at its own sample edge, even if the input changes afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slaveMode | input | 1 | 1 = exposure window set by trig, 0 = internal timing |
| pipeMode | input | 1 | 1 = exposure overlaps readout, 0 = serial |
| expDelay | input | EXP_W | Cycles of extra reset before integration (internal timing) |
| expLen | input | EXP_W | Integration length in cycles (internal timing) |
| numLines | input | LINE_W | Lines read per frame |
| trig | input | 1 | Exposure window level in triggered timing |
| pixRst | output | 1 | Array-wide pixel reset, 1 = held in reset |
| sampleStb | output | 1 | One-cycle global sample strobe |
| rowAddr | output | LINE_W | Row being read out |
| lineValid | output | 1 | Data window of the current line |
| frameValid | output | 1 | Span of the line sequence of a frame |
| lateTrig | output | 1 | One-cycle flag: an exposure end was deferred |

## Verification
The bench aims at the deferral path, where an exposure ends during a busy readout, in both internal and triggered timing. A design that sampled at once would tear the running frame: its sample spacing and integration length would come out shorter than R+1 and R-expDelay. The bench also compares the exact spacing of frames in the serial and overlapped orderings. An off-by-one in any overhead counter shows up there as a wrong period, a wrong frame-valid rise or a wrong row gap. Finally, it changes numLines and the mode bits just after a sample. A design that read them live instead of at the boundary would read out the wrong number of lines for the frame already sampled.

// File: rtl/gs_seq_pkg.sv
package gs_seq_pkg;

  typedef enum logic [2:0] {
    XS_BOOT,
    XS_WAIT,
    XS_ARM,
    XS_DLY,
    XS_INT,
    XS_HOLD
  } expState_t;

  typedef enum logic [1:0] {
    RO_IDLE,
    RO_FOT,
    RO_ROT,
    RO_DATA
  } roState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic expClr;
    logic phClr;
    logic rowClr;
    logic rowInc;
    logic linesLd;
  } seqStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic dlyDone;
    logic intDone;
    logic fotDone;
    logic rotDone;
    logic dataDone;
    logic lastRow;
  } seqFlags_t;

endpackage

// File: rtl/gs_seq_dp.sv
module gs_seq_dp
  import gs_seq_pkg::*;
#(
  parameter int EXP_W    = 16,
  parameter int LINE_W   = 8,
  parameter int FOT_CYC  = 4,
  parameter int ROT_CYC  = 2,
  parameter int LINE_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobe_t        stb,
  input  logic [EXP_W-1:0]  expDelay,
  input  logic [EXP_W-1:0]  expLen,
  input  logic [LINE_W-1:0] numLines,
  output seqFlags_t         flg,
  output logic [LINE_W-1:0] rowAddr
);

  localparam int PH_MAX = (FOT_CYC > ROT_CYC) ?
                          ((FOT_CYC > LINE_CYC) ? FOT_CYC : LINE_CYC) :
                          ((ROT_CYC > LINE_CYC) ? ROT_CYC : LINE_CYC);
  localparam int PH_W = $clog2(PH_MAX + 1);

  logic [EXP_W-1:0]  expCnt;
  logic [EXP_W-1:0]  expLenEff;
  logic [PH_W-1:0]   phCnt;
  logic [LINE_W-1:0] rowCnt;
  logic [LINE_W-1:0] linesLat;
  logic [LINE_W-1:0] lastIdx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      expCnt   <= '0;
      phCnt    <= '0;
      rowCnt   <= '0;
      linesLat <= '0;
    end else begin
      expCnt <= stb.expClr ? '0 : expCnt + EXP_W'(1);
      phCnt  <= stb.phClr  ? '0 : phCnt + PH_W'(1);
      if (stb.rowClr)      rowCnt <= '0;
      else if (stb.rowInc) rowCnt <= rowCnt + LINE_W'(1);
      if (stb.linesLd)     linesLat <= numLines;
    end
  end

  always_comb begin
    expLenEff    = (expLen == '0) ? EXP_W'(1) : expLen;
    lastIdx      = (linesLat == '0) ? '0 : linesLat - LINE_W'(1);
    flg.dlyDone  = (expCnt == expDelay);
    flg.intDone  = (expCnt == expLenEff - EXP_W'(1));
    flg.fotDone  = (phCnt == PH_W'(FOT_CYC - 1));
    flg.rotDone  = (phCnt == PH_W'(ROT_CYC - 1));
    flg.dataDone = (phCnt == PH_W'(LINE_CYC - 1));
    flg.lastRow  = (rowCnt == lastIdx);
  end

  assign rowAddr = rowCnt;

  // R5
  row_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.rowInc |-> !flg.lastRow);

endmodule

// File: rtl/gs_seq_ctrl.sv
module gs_seq_ctrl
  import gs_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slaveMode,
  input  logic       pipeMode,
  input  logic       trig,
  input  seqFlags_t  flg,
  output seqStrobe_t stb,
  output logic       pixRst,
  output logic       sampleStb,
  output logic       lateTrig,
  output logic       lineValid,
  output logic       frameValid
);

  expState_t xState, xNext, afterSample, startState;
  roState_t  roState, roNext;
  logic      slaveLat;
  logic      roIdle, endReq, sampleEvt, lateEvt;

  always_comb begin
    roIdle      = (roState == RO_IDLE);
    endReq      = (xState == XS_INT) && (slaveLat ? !trig : flg.intDone);
    sampleEvt   = (endReq || (xState == XS_HOLD)) && roIdle;
    lateEvt     = endReq && !roIdle;
    afterSample = !pipeMode ? XS_WAIT : (slaveMode ? XS_ARM : XS_DLY);
    startState  = slaveLat ? XS_ARM : XS_DLY;

    xNext = xState;
    case (xState)
      XS_BOOT: xNext = XS_WAIT;
      XS_WAIT: if (roIdle) xNext = startState;
      XS_ARM:  if (trig) xNext = XS_INT;
      XS_DLY:  if (flg.dlyDone) xNext = XS_INT;
      XS_INT:  if (sampleEvt) xNext = afterSample;
               else if (lateEvt) xNext = XS_HOLD;
      XS_HOLD: if (sampleEvt) xNext = afterSample;
      default: xNext = XS_BOOT;
    endcase

    roNext = roState;
    case (roState)
      RO_IDLE: if (sampleEvt) roNext = RO_FOT;
      RO_FOT:  if (flg.fotDone) roNext = RO_ROT;
      RO_ROT:  if (flg.rotDone) roNext = RO_DATA;
      RO_DATA: if (flg.dataDone) roNext = flg.lastRow ? RO_IDLE : RO_ROT;
      default: roNext = RO_IDLE;
    endcase

    stb.expClr  = (xNext != xState) || sampleEvt;
    stb.phClr   = (roNext != roState) || sampleEvt;
    stb.rowClr  = sampleEvt;
    stb.rowInc  = (roState == RO_DATA) && flg.dataDone && !flg.lastRow;
    stb.linesLd = sampleEvt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xState    <= XS_BOOT;
      roState   <= RO_IDLE;
      slaveLat  <= 1'b0;
      sampleStb <= 1'b0;
      lateTrig  <= 1'b0;
    end else begin
      xState    <= xNext;
      roState   <= roNext;
      sampleStb <= sampleEvt;
      lateTrig  <= lateEvt;
      if ((xState == XS_BOOT) || sampleEvt) slaveLat <= slaveMode;
    end
  end

  assign pixRst     = (xState inside {XS_BOOT, XS_WAIT, XS_ARM, XS_DLY});
  assign frameValid = (roState == RO_ROT) || (roState == RO_DATA);
  assign lineValid  = (roState == RO_DATA);

  // R2
  sample_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sampleStb |-> pixRst);

  // R10
  sample_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sampleStb |-> $past(roState) == RO_IDLE);

  // R10
  late_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lateTrig |-> $past(roState) != RO_IDLE);

  // R3
  fot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sampleStb |=> !frameValid);

  // R2
  strobe_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sampleStb |=> !sampleStb);

endmodule

// File: rtl/gs_readout_seq.sv
module gs_readout_seq
  import gs_seq_pkg::*;
#(
  parameter int EXP_W    = 16,
  parameter int LINE_W   = 8,
  parameter int FOT_CYC  = 4,
  parameter int ROT_CYC  = 2,
  parameter int LINE_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slaveMode,
  input  logic              pipeMode,
  input  logic [EXP_W-1:0]  expDelay,
  input  logic [EXP_W-1:0]  expLen,
  input  logic [LINE_W-1:0] numLines,
  input  logic              trig,
  output logic              pixRst,
  output logic              sampleStb,
  output logic [LINE_W-1:0] rowAddr,
  output logic              lineValid,
  output logic              frameValid,
  output logic              lateTrig
);

  seqStrobe_t stb;
  seqFlags_t  flg;

  gs_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .slaveMode  (slaveMode),
    .pipeMode   (pipeMode),
    .trig       (trig),
    .flg        (flg),
    .stb        (stb),
    .pixRst     (pixRst),
    .sampleStb  (sampleStb),
    .lateTrig   (lateTrig),
    .lineValid  (lineValid),
    .frameValid (frameValid)
  );

  gs_seq_dp #(
    .EXP_W    (EXP_W),
    .LINE_W   (LINE_W),
    .FOT_CYC  (FOT_CYC),
    .ROT_CYC  (ROT_CYC),
    .LINE_CYC (LINE_CYC)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .expDelay (expDelay),
    .expLen   (expLen),
    .numLines (numLines),
    .flg      (flg),
    .rowAddr  (rowAddr)
  );

endmodule

// File: tb/gs_readout_seq_bench.sv
module gs_readout_seq_bench;

  localparam int CLK_PER  = 10;
  localparam int EXP_W    = 16;
  localparam int LINE_W   = 8;
  localparam int FOT_CYC  = 4;
  localparam int ROT_CYC  = 2;
  localparam int LINE_CYC = 8;
  localparam int WD_CYC   = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slaveMode = 1'b0;
  logic pipeMode = 1'b0;
  logic [EXP_W-1:0] expDelay = '0;
  logic [EXP_W-1:0] expLen = '0;
  logic [LINE_W-1:0] numLines = '0;
  logic trig = 1'b0;
  logic pixRst, sampleStb, lineValid, frameValid, lateTrig;
  logic [LINE_W-1:0] rowAddr;

  always #(CLK_PER/2) clk = ~clk;

  gs_readout_seq #(
    .EXP_W(EXP_W), .LINE_W(LINE_W), .FOT_CYC(FOT_CYC),
    .ROT_CYC(ROT_CYC), .LINE_CYC(LINE_CYC)
  ) u_gs_readout_seq (
    .clk(clk), .rst_n(rst_n), .slaveMode(slaveMode), .pipeMode(pipeMode),
    .expDelay(expDelay), .expLen(expLen), .numLines(numLines), .trig(trig),
    .pixRst(pixRst), .sampleStb(sampleStb), .rowAddr(rowAddr),
    .lineValid(lineValid), .frameValid(frameValid), .lateTrig(lateTrig)
  );

  typedef struct {
    int    period;
    int    intLen;
    int    late;
    int    lines;
    string perTag;
    string intTag;
    string lineTag;
  } expItem_t;

  expItem_t expQ[$];
  int nChk = 0;
  int nFail = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic pushExp(input int per, input int il, input int lt, input int ln,
                         input string pt, input string it, input string lnt);
    expItem_t e;
    e.period = per; e.intLen = il; e.late = lt; e.lines = ln;
    e.perTag = pt; e.intTag = it; e.lineTag = lnt;
    expQ.push_back(e);
  endtask

  // monitor / scoreboard
  int cyc = 0, lastSamp = 0, sinceSamp = 0, lowRun = 0, lateSeen = 0;
  int pendLines = -1, lineIdx = 0, fvLen = 0, gap = 0, runLen = 0;
  string pendTag = "R5";
  bit prevFv = 0, prevLv = 0, prevPix = 1;

  always @(negedge clk) begin
    if (!rst_n) begin
      prevFv = 0; prevLv = 0; prevPix = 1; lowRun = 0; sinceSamp = 0; lateSeen = 0;
    end else begin
      expItem_t it;
      cyc++;
      sinceSamp++;
      if (!pixRst) begin
        if (prevPix) lowRun = 0;
        lowRun++;
      end
      if (lateTrig) lateSeen = 1;
      if (sampleStb) begin
        chk(pixRst == 1'b1, "R2 pixRst in sample cycle", int'(pixRst), 1);
        if (expQ.size() == 0) chk(1'b0, "R2 unexpected sample", 1, 0);
        else begin
          it = expQ.pop_front();
          if (it.period >= 0) chk(cyc - lastSamp == it.period,
                                  {it.perTag, " sample period"}, cyc - lastSamp, it.period);
          if (it.intLen >= 0) chk(lowRun == it.intLen,
                                  {it.intTag, " integration length"}, lowRun, it.intLen);
          if (it.late >= 0) chk(lateSeen == it.late, "R10 late flag", lateSeen, it.late);
          pendLines = it.lines;
          pendTag = it.lineTag;
        end
        lastSamp = cyc; sinceSamp = 0; lateSeen = 0;
      end
      if (frameValid && !prevFv) begin
        chk(sinceSamp == FOT_CYC, "R3 frame overhead", sinceSamp, FOT_CYC);
        lineIdx = 0; fvLen = 0; gap = 0;
      end
      if (lineValid && !prevLv) begin
        chk(gap == ROT_CYC, "R4 row overhead", gap, ROT_CYC);
        chk(int'(rowAddr) == lineIdx, "R4 row address", int'(rowAddr), lineIdx);
        runLen = 0;
      end
      if (!lineValid && prevLv) begin
        chk(runLen == LINE_CYC, "R4 line data length", runLen, LINE_CYC);
        lineIdx++;
        gap = 0;
      end
      if (lineValid) runLen++;
      if (frameValid) fvLen++;
      if (frameValid && !lineValid) gap++;
      if (!frameValid && prevFv && pendLines >= 0) begin
        chk(lineIdx == pendLines, {pendTag, " line count"}, lineIdx, pendLines);
        chk(fvLen == pendLines * (ROT_CYC + LINE_CYC), "R5 frame-valid length",
            fvLen, pendLines * (ROT_CYC + LINE_CYC));
      end
      prevFv = frameValid; prevLv = lineValid; prevPix = pixRst;
    end
  end

  task automatic waitSample();
    do begin
      @(negedge clk); #1;
    end while (!sampleStb);
  endtask

  task automatic drain();
    while (expQ.size() != 0) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic pulse(input int gapCyc, input int highCyc);
    repeat (gapCyc) @(negedge clk);
    trig = 1'b1;
    repeat (highCyc) @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog R2 actual=running expected=done");
    finishRun();
  end

  initial begin
    expDelay = 3; expLen = 10; numLines = 3;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pixRst == 1'b1, "R1 pixRst", int'(pixRst), 1);
    chk(sampleStb == 1'b0, "R1 sampleStb", int'(sampleStb), 0);
    chk(frameValid == 1'b0, "R1 frameValid", int'(frameValid), 0);
    chk(lineValid == 1'b0, "R1 lineValid", int'(lineValid), 0);
    chk(lateTrig == 1'b0, "R1 lateTrig", int'(lateTrig), 0);
    chk(rowAddr == '0, "R1 rowAddr", int'(rowAddr), 0);

    // internal timing, serial ordering: R=34, period 34+3+10+2
    pushExp(-1, 10, 0, 3, "R7", "R6", "R5");
    for (int k = 0; k < 3; k++) pushExp(49, 10, 0, 3, "R7", "R6", "R5");
    rst_n = 1'b1;
    drain();

    // internal timing, overlapped ordering: period max(2+40+1, 35)
    pipeMode = 1'b1; expDelay = 2; expLen = 40;
    pushExp(-1, -1, -1, -1, "R8", "R6", "R5");
    for (int k = 0; k < 3; k++) pushExp(43, 40, 0, 3, "R8", "R6", "R5");
    drain();

    // overlapped, exposure shorter than readout: deferral, R=44
    expDelay = 1; expLen = 5; numLines = 4;
    pushExp(-1, -1, -1, -1, "R8", "R10", "R5");
    for (int k = 0; k < 3; k++) pushExp(45, 43, 1, 4, "R10", "R10", "R5");
    drain();

    // triggered timing, serial ordering, expLen must be ignored
    slaveMode = 1'b1; pipeMode = 1'b0; numLines = 2; expLen = 3;
    pushExp(-1, -1, -1, -1, "R9", "R9", "R5");
    for (int k = 0; k < 3; k++) begin
      pushExp(37, 7, 0, 2, "R9", "R9", "R5");
      waitSample();
      pulse(29, 7);
    end
    waitSample();

    // line count changed after the sample edge applies to the next frame only
    pipeMode = 1'b1; numLines = 4;
    pushExp(37, 7, 0, 4, "R9", "R9", "R11");
    pulse(29, 7);
    // triggered, overlapped: trigger ends during readout, deferral
    for (int k = 0; k < 3; k++) begin
      pushExp(45, 42, 1, 4, "R10", "R10", "R5");
      waitSample();
      pulse(2, 6);
    end
    waitSample();
    repeat (60) @(negedge clk);
    chk(expQ.size() == 0, "R2 all expected samples seen", expQ.size(), 0);
    finishRun();
  end

endmodule